// File: doc/BRIEF.md
# TDM Audio Serial Receiver

This block receives a time-division-multiplexed audio stream. Each frame carries a programmable number of equal slots. On every bit-clock tick it samples one serial data bit. It cuts each slot down to the programmed sample width, taking the sample from either the leading or the trailing bits of the slot. The value is then extended to 32 bits and stored in a small receive FIFO. A request line tells the data mover that the FIFO holds more samples than a programmed threshold.

The receiver owns the frame timing of the whole audio port. In master mode it generates frame sync from a programmed period and pulse width, counted in bit ticks. In slave mode it follows an external frame-sync pin of programmable polarity. Either way it emits a one-cycle frame-start pulse that the transmit direction uses as its own timing. For that reason the receiver has to be enabled whenever either direction runs.

Configuration arrives through two write ports. The serial-port word carries enable, master, polarity, sync width and period, plus self-clearing reset and flush commands. It is accepted only when its bit 31 is set in the same write. The format word carries sample size, slot length, slot count, data delay, justification and FIFO threshold.

Top module: `tdm_rx`

## Requirements
- R1: After reset, `rd_valid`, `req`, `overrun`, `resync`, `frame_tick` and `fs_out` are 0 and `fs_oe` is 0.
- R2: A write on `sp_wr` whose bit 31 is 0 changes nothing. With the block disabled, a following frame produces no sample and no `frame_tick`.
- R3: A frame starts on a bit tick where the frame-sync level is active and was inactive on the previous tick. With delay bit 16 of the format word at 0, that tick carries the first data bit of slot 0. With delay at 1, the first data bit follows one tick later. Bits arrive MSB first and samples leave `rd_data` in arrival order.
- R4: With justify bit 17 at 0, the sample is the first N bits of the slot and the remaining bits of the slot are ignored.
- R5: With justify bit 17 at 1, the sample is the last N bits of the slot and the leading bits are ignored.
- R6: The sample-size field (bits 2:0) and the slot-length field (bits 6:4) use codes 0..5 for 8, 12, 16, 20, 24 and 32 bits. Each sample is right-aligned and sign-extended to 32 bits.
- R7: A frame holds (bits 14:8)+1 slots. After the last slot, data ticks are ignored until the next frame start.
- R8: Serial-port bit 4 set makes the low level of `fs_in` the active frame-sync level. The same bit inverts `fs_out`.
- R9: With master bit 3 set, `fs_oe` is 1. The active sync level lasts for (bits 15:8)+1 ticks and repeats every (bits 27:16)+1 ticks, starting on the first tick after enable and reset. `frame_tick` pulses once per generated frame.
- R10: `req` is 1 exactly when the FIFO count exceeds the threshold in format bits 31:24. A threshold of 0 requests on any stored sample.
- R11: A sample completed while the FIFO holds its full depth is dropped, and it sets the sticky `overrun` flag. Stored samples are kept.
- R12: In slave mode, a frame start that arrives before the last slot has finished restarts counting at slot 0 and sets the sticky `resync` flag.
- R13: An accepted write with reset bit 1 clears the framing state and both flags. Flush bit 2 empties the FIFO. While enable bit 0 is 0, ticks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sp_wr | input | 1 | Serial-port word write strobe |
| sp_wdata | input | 32 | Serial-port word; bit 31 must be set for the write to take effect |
| fmt_wr | input | 1 | Format word write strobe |
| fmt_wdata | input | 32 | Format word |
| bclk_en | input | 1 | One-cycle pulse per serial bit time |
| fs_in | input | 1 | External frame sync (slave mode) |
| sd | input | 1 | Serial data |
| fs_out | output | 1 | Generated frame sync |
| fs_oe | output | 1 | High when this port drives frame sync |
| frame_tick | output | 1 | One-cycle pulse per frame start, shared with the transmitter |
| rd_en | input | 1 | Pop the FIFO head |
| rd_data | output | 32 | FIFO head sample |
| rd_valid | output | 1 | FIFO not empty |
| req | output | 1 | FIFO count above threshold |
| overrun | output | 1 | Sticky: a sample was dropped |
| resync | output | 1 | Sticky: early frame start seen in slave mode |

## Verification
The bound checker watches, on every cycle, the properties that involve only the FIFO count and the configuration state. These are the occupancy bound, the quiet request on an empty FIFO, the rejection of serial-port writes without bit 31, the setting and holding of the overrun flag, the flush and the enable gating of frame starts. Sample extraction itself can only be shown by the bench's scenarios. That covers justification, data delay, the size codes, sign extension, sync polarity, resynchronisation and the generated sync pattern. In those scenarios a scoreboard predicts each 32-bit word from the bit stream it drives and compares the words in order as they leave the FIFO.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
   localparam int SAMPLE_W = 32;

   // serial-port word layout
   localparam int SP_WEN     = 31;
   localparam int SP_EN      = 0;
   localparam int SP_RST     = 1;
   localparam int SP_FLUSH   = 2;
   localparam int SP_MASTER  = 3;
   localparam int SP_FSLOW   = 4;
   localparam int SP_WID_LSB = 8;
   localparam int SP_PER_LSB = 16;

   // format word layout
   localparam int FM_SSZ_LSB   = 0;
   localparam int FM_SLEN_LSB  = 4;
   localparam int FM_SLOTS_LSB = 8;
   localparam int FM_DLY       = 16;
   localparam int FM_RJ        = 17;
   localparam int FM_THR_LSB   = 24;

   // width code shared by sample size and slot length
   function automatic logic [5:0] code_bits(input logic [2:0] code);
      case (code)
         3'd0:    return 6'd8;
         3'd1:    return 6'd12;
         3'd2:    return 6'd16;
         3'd3:    return 6'd20;
         3'd4:    return 6'd24;
         default: return 6'd32;
      endcase
   endfunction

   function automatic logic [SAMPLE_W-1:0] widen(input logic [SAMPLE_W-1:0] raw,
                                                 input logic [5:0] n,
                                                 input logic sgn);
      logic [SAMPLE_W-1:0] m;
      logic fill;
      m    = (n >= 6'd32) ? '1 : ((SAMPLE_W'(1) << n) - SAMPLE_W'(1));
      fill = sgn & raw[n - 6'd1];
      return (raw & m) | (fill ? ~m : '0);
   endfunction
endpackage

// File: rtl/tdm_rx_fsgen.sv
module tdm_rx_fsgen #(
   parameter int PER_W = 12,
   parameter int WID_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic             en,
   input  logic             master,
   input  logic             fs_low,
   input  logic [WID_W-1:0] wid,
   input  logic [PER_W-1:0] per,
   input  logic             fs_in,
   output logic             fs_out,
   output logic             start
);
   logic [PER_W-1:0] fcnt_q;
   logic             prev_q;
   logic             gen_act;
   logic             act;

   assign gen_act = (fcnt_q <= PER_W'(wid));
   assign act     = master ? gen_act : (fs_in ^ fs_low);
   assign start   = tick & act & ~prev_q;
   assign fs_out  = (master & en) ? (gen_act ^ fs_low) : fs_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt_q <= '0;
         prev_q <= 1'b0;
      end else if (clr) begin
         fcnt_q <= '0;
         prev_q <= 1'b0;
      end else if (tick) begin
         prev_q <= act;
         if (master) fcnt_q <= (fcnt_q == per) ? '0 : fcnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
   import tdm_rx_pkg::*;
#(
   parameter int SLOT_W   = 7,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                tick,
   input  logic                start,
   input  logic                sd,
   input  logic                slave,
   input  logic [2:0]          ssz_code,
   input  logic [2:0]          slen_code,
   input  logic [SLOT_W-1:0]   nslots_m1,
   input  logic                dly,
   input  logic                rj,
   output logic                push,
   output logic [SAMPLE_W-1:0] pdata,
   output logic                frame_tick,
   output logic                resync_pulse
);
   logic                act_q, act_d;
   logic [SLOT_W-1:0]   slot_q, slot_d, pslot;
   logic [5:0]          bit_q, bit_d, pbit;
   logic [SAMPLE_W-1:0] sh_q, sh_d;
   logic                push_d, resync_d, proc, sgn;
   logic [5:0]          nsz, nlen, lo;

   generate
      if (SIGN_EXT) begin : g_signed
         assign sgn = 1'b1;
      end else begin : g_unsigned
         assign sgn = 1'b0;
      end
   endgenerate

   assign nsz  = code_bits(ssz_code);
   assign nlen = code_bits(slen_code);
   assign lo   = (nsz >= nlen) ? 6'd0 : nlen - nsz;

   always_comb begin
      act_d    = act_q;
      slot_d   = slot_q;
      bit_d    = bit_q;
      sh_d     = sh_q;
      push_d   = 1'b0;
      resync_d = 1'b0;
      proc     = 1'b0;
      pslot    = slot_q;
      pbit     = bit_q;
      if (tick) begin
         if (start) begin
            resync_d = act_q & slave;
            act_d    = 1'b1;
            slot_d   = '0;
            bit_d    = '0;
            pslot    = '0;
            pbit     = '0;
            proc     = ~dly;
         end else begin
            proc = act_q;
         end
         if (proc) begin
            if (rj ? (pbit >= lo) : (pbit < nsz)) sh_d = {sh_q[SAMPLE_W-2:0], sd};
            if (pbit == nlen - 6'd1) begin
               push_d = 1'b1;
               bit_d  = '0;
               if (pslot == nslots_m1) act_d = 1'b0;
               else                    slot_d = pslot + 1'b1;
            end else begin
               bit_d = pbit + 6'd1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q        <= 1'b0;
         slot_q       <= '0;
         bit_q        <= '0;
         sh_q         <= '0;
         push         <= 1'b0;
         pdata        <= '0;
         frame_tick   <= 1'b0;
         resync_pulse <= 1'b0;
      end else if (clr) begin
         act_q        <= 1'b0;
         slot_q       <= '0;
         bit_q        <= '0;
         sh_q         <= '0;
         push         <= 1'b0;
         frame_tick   <= 1'b0;
         resync_pulse <= 1'b0;
      end else begin
         act_q        <= act_d;
         slot_q       <= slot_d;
         bit_q        <= bit_d;
         sh_q         <= sh_d;
         push         <= push_d;
         frame_tick   <= tick & start;
         resync_pulse <= resync_d;
         if (push_d) pdata <= widen(sh_d, nsz, sgn);
      end
   end
endmodule

// File: rtl/tdm_rx_fifo.sv
module tdm_rx_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 32,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr,
   input  logic [W-1:0]     wdata,
   input  logic             rd,
   output logic [W-1:0]     rdata,
   output logic [CNT_W-1:0] cnt,
   output logic             drop
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          full, empty, do_wr, do_rd;

   assign full  = (cnt == CNT_W'(DEPTH));
   assign empty = (cnt == '0);
   assign do_wr = wr & ~full;
   assign do_rd = rd & ~empty;
   assign drop  = wr & full;
   assign rdata = mem[rp];

   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_wr) wp <= nxt(wp);
         if (do_rd) rp <= nxt(rp);
         case ({do_wr, do_rd})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
   import tdm_rx_pkg::*;
#(
   parameter int FIFO_DEPTH = 8,
   parameter int SLOT_W     = 7,
   parameter int WID_W      = 8,
   parameter int PER_W      = 12,
   parameter bit SIGN_EXT   = 1'b1,
   localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sp_wr,
   input  logic [31:0] sp_wdata,
   input  logic        fmt_wr,
   input  logic [31:0] fmt_wdata,
   input  logic        bclk_en,
   input  logic        fs_in,
   input  logic        sd,
   output logic        fs_out,
   output logic        fs_oe,
   output logic        frame_tick,
   input  logic        rd_en,
   output logic [31:0] rd_data,
   output logic        rd_valid,
   output logic        req,
   output logic        overrun,
   output logic        resync
);
   generate
      if (WID_W > 8 || PER_W > 15 || PER_W < WID_W || SLOT_W > 8 ||
          SLOT_W < 1 || CNT_W > 8 || FIFO_DEPTH < 2) begin : g_bad_cfg
         $error("tdm_rx: parameter set does not fit the configuration words");
      end
   endgenerate

   logic             en_q, master_q, fslow_q, dly_q, rj_q;
   logic [WID_W-1:0] wid_q;
   logic [PER_W-1:0] per_q;
   logic [2:0]       ssz_q, slen_q;
   logic [SLOT_W-1:0] slots_q;
   logic [CNT_W-1:0] thr_q, fifo_cnt;
   logic             sp_take, clr, flush, tick, start;
   logic             dz_push, rs_pulse, drop;
   logic [31:0]      dz_data;

   assign sp_take = sp_wr & sp_wdata[SP_WEN];
   assign clr     = sp_take & sp_wdata[SP_RST];
   assign flush   = sp_take & sp_wdata[SP_FLUSH];
   assign tick    = bclk_en & en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0; master_q <= 1'b0; fslow_q <= 1'b0;
         wid_q <= '0; per_q <= '0;
      end else if (sp_take) begin
         en_q     <= sp_wdata[SP_EN];
         master_q <= sp_wdata[SP_MASTER];
         fslow_q  <= sp_wdata[SP_FSLOW];
         wid_q    <= sp_wdata[SP_WID_LSB +: WID_W];
         per_q    <= sp_wdata[SP_PER_LSB +: PER_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ssz_q <= '0; slen_q <= '0; slots_q <= '0;
         dly_q <= 1'b0; rj_q <= 1'b0; thr_q <= '0;
      end else if (fmt_wr) begin
         ssz_q   <= fmt_wdata[FM_SSZ_LSB +: 3];
         slen_q  <= fmt_wdata[FM_SLEN_LSB +: 3];
         slots_q <= fmt_wdata[FM_SLOTS_LSB +: SLOT_W];
         dly_q   <= fmt_wdata[FM_DLY];
         rj_q    <= fmt_wdata[FM_RJ];
         thr_q   <= fmt_wdata[FM_THR_LSB +: CNT_W];
      end
   end

   tdm_rx_fsgen #(.PER_W(PER_W), .WID_W(WID_W)) u_fsgen (
      .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .en(en_q),
      .master(master_q), .fs_low(fslow_q), .wid(wid_q), .per(per_q),
      .fs_in(fs_in), .fs_out(fs_out), .start(start)
   );

   tdm_rx_deser #(.SLOT_W(SLOT_W), .SIGN_EXT(SIGN_EXT)) u_deser (
      .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .start(start),
      .sd(sd), .slave(~master_q), .ssz_code(ssz_q), .slen_code(slen_q),
      .nslots_m1(slots_q), .dly(dly_q), .rj(rj_q), .push(dz_push),
      .pdata(dz_data), .frame_tick(frame_tick), .resync_pulse(rs_pulse)
   );

   tdm_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr(dz_push), .wdata(dz_data),
      .rd(rd_en), .rdata(rd_data), .cnt(fifo_cnt), .drop(drop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overrun <= 1'b0;
         resync  <= 1'b0;
      end else if (clr) begin
         overrun <= 1'b0;
         resync  <= 1'b0;
      end else begin
         if (drop)     overrun <= 1'b1;
         if (rs_pulse) resync  <= 1'b1;
      end
   end

   assign fs_oe    = master_q;
   assign rd_valid = (fifo_cnt != '0);
   assign req      = (fifo_cnt > thr_q);
endmodule

// File: rtl/tdm_rx_chk.sv
module tdm_rx_chk #(
   parameter int FIFO_DEPTH = 8,
   parameter int CNT_W      = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sp_wr,
   input logic [31:0]      sp_wdata,
   input logic             en_q,
   input logic [CNT_W-1:0] fifo_cnt,
   input logic             fifo_push,
   input logic             overrun,
   input logic             frame_tick,
   input logic             rd_valid,
   input logic             req
);
   logic sp_clr;
   assign sp_clr = sp_wr & sp_wdata[31] & sp_wdata[1];

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= CNT_W'(FIFO_DEPTH)); // R11
   AST_WEN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      sp_wr && !sp_wdata[31] |=> $stable(en_q)); // R2
   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push && fifo_cnt == CNT_W'(FIFO_DEPTH) && !sp_clr |=> overrun); // R11
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overrun && !sp_clr |=> overrun); // R11
   AST_REQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt == '0 |-> !req); // R10
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      sp_wr && sp_wdata[31] && sp_wdata[2] |=> !rd_valid); // R13
   AST_TICK_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick |-> $past(en_q)); // R13
endmodule

bind tdm_rx tdm_rx_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sp_wr(sp_wr), .sp_wdata(sp_wdata), .en_q(en_q),
   .fifo_cnt(fifo_cnt), .fifo_push(dz_push), .overrun(overrun),
   .frame_tick(frame_tick), .rd_valid(rd_valid), .req(req)
);

// File: tb/tb_tdm_rx.sv
module tb_tdm_rx;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        sp_wr = 1'b0, fmt_wr = 1'b0;
   logic [31:0] sp_wdata = '0, fmt_wdata = '0;
   logic        bclk_en = 1'b0, fs_in = 1'b0, sd = 1'b0, rd_en = 1'b0;
   logic        fs_out, fs_oe, frame_tick, rd_valid, req, overrun, resync;
   logic [31:0] rd_data;

   int          n_chk = 0, n_fail = 0, ft_cnt = 0, tk = 0;
   logic [31:0] exp_q[$];
   logic [31:0] sv [0:15];
   logic        fs_hist [0:63];
   bit          mon_on = 1'b0, expect_on = 1'b1, done = 1'b0;
   logic        last_fs;

   tdm_rx #(.FIFO_DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .sp_wr(sp_wr), .sp_wdata(sp_wdata),
      .fmt_wr(fmt_wr), .fmt_wdata(fmt_wdata), .bclk_en(bclk_en), .fs_in(fs_in),
      .sd(sd), .fs_out(fs_out), .fs_oe(fs_oe), .frame_tick(frame_tick),
      .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .req(req),
      .overrun(overrun), .resync(resync)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int bits_of(input int code);
      case (code) 0: return 8; 1: return 12; 2: return 16; 3: return 20; 4: return 24; default: return 32; endcase
   endfunction

   function automatic logic [31:0] sx(input logic [31:0] v, input int n);
      logic [31:0] m;
      if (n >= 32) return v;
      m = (32'd1 << n) - 32'd1;
      return v[n-1] ? (v | ~m) : (v & m);
   endfunction

   function automatic logic [31:0] spw(input bit en, input bit rs, input bit fl, input bit ms,
                                       input bit low, input int wid, input int per);
      return 32'h8000_0000 | 32'(en) | (32'(rs) << 1) | (32'(fl) << 2) | (32'(ms) << 3) |
             (32'(low) << 4) | (32'(wid) << 8) | (32'(per) << 16);
   endfunction

   function automatic logic [31:0] fmw(input int szc, input int slc, input int nsl,
                                       input bit dly, input bit rj, input int thr);
      return 32'(szc) | (32'(slc) << 4) | (32'(nsl - 1) << 8) | (32'(dly) << 16) |
             (32'(rj) << 17) | (32'(thr) << 24);
   endfunction

   task automatic wr_sp(input logic [31:0] d);
      @(negedge clk); sp_wr = 1'b1; sp_wdata = d;
      @(negedge clk); sp_wr = 1'b0;
   endtask

   task automatic wr_fmt(input logic [31:0] d);
      @(negedge clk); fmt_wr = 1'b1; fmt_wdata = d;
      @(negedge clk); fmt_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick(input logic f, input logic b);
      @(negedge clk); fs_in = f; sd = b; bclk_en = 1'b1; last_fs = fs_out;
      if (tk < 64) fs_hist[tk] = last_fs;
      tk++;
      @(negedge clk); bclk_en = 1'b0;
   endtask

   task automatic push_exp(input logic [31:0] v);
      if (!expect_on) return;
      if (!mon_on && exp_q.size() >= DEPTH) return;
      exp_q.push_back(v);
   endtask

   // driver: serialise sv[] into one frame and predict the samples
   task automatic send_frame(input int nsl, input int szc, input int slc, input bit rj,
                             input bit dly, input bit low, input int cut);
      int sz, sl, total, pos, s, i, lo;
      logic b;
      sz = bits_of(szc); sl = bits_of(slc); lo = sl - sz;
      total = (cut >= 0) ? cut : nsl * sl;
      for (int t = 0; t < total + int'(dly); t++) begin
         pos = t - int'(dly); b = 1'b1; s = 0; i = 0;
         if (pos >= 0) begin
            s = pos / sl; i = pos % sl;
            if (rj) b = (i >= lo) ? sv[s][sz-1-(i-lo)] : i[0];
            else    b = (i < sz)  ? sv[s][sz-1-i]      : ~i[0];
         end
         tick(logic'(t == 0) ^ low, b);
         if (pos >= 0 && i == sl - 1) push_exp(sx(sv[s], sz));
      end
      fs_in = low;
   endtask

   task automatic drained(input string tag);
      idle(10);
      chk(exp_q.size() == 0 && !rd_valid, tag, 32'(exp_q.size()), 0);
   endtask

   // monitor: pop and compare in order
   initial begin
      forever begin
         @(negedge clk);
         if (mon_on && rd_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R3 unexpected sample", rd_data, 0);
            else begin
               logic [31:0] e;
               e = exp_q.pop_front();
               chk(rd_data == e, "R3/R4/R5/R6 sample value", rd_data, e);
            end
            rd_en = 1'b1;
         end else rd_en = 1'b0;
      end
   end

   always @(negedge clk) if (frame_tick) ft_cnt++;

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      idle(3); rst_n = 1'b1; idle(2);
      // R1 reset state
      chk(!rd_valid && !req && !overrun && !resync && !frame_tick && !fs_out && !fs_oe,
          "R1 reset outputs", {25'd0, rd_valid, req, overrun, resync, frame_tick, fs_out, fs_oe}, 0);

      // R2 write without bit 31 ignored
      wr_fmt(fmw(2, 5, 2, 1, 0, 7));
      wr_sp(32'h0000_0001);
      mon_on = 1'b1; expect_on = 1'b0;
      sv[0] = 32'h8001; sv[1] = 32'h1234;
      send_frame(2, 2, 5, 0, 1, 0, -1);
      idle(5);
      chk(!rd_valid && ft_cnt == 0, "R2 unqualified write", 32'(ft_cnt), 0);
      expect_on = 1'b1;

      // R3 R4 R6 left justified 16 in 32, delay 1
      wr_sp(spw(1, 0, 0, 0, 0, 0, 0));
      send_frame(2, 2, 5, 0, 1, 0, -1);
      sv[0] = 32'h7FFF; sv[1] = 32'hFFFF;
      send_frame(2, 2, 5, 0, 1, 0, -1);
      drained("R3 left/delay1 frames drained");

      // R5 R6 right justified 12 in 16, delay 0, 4 slots
      wr_fmt(fmw(1, 2, 4, 0, 1, 7));
      sv[0] = 32'hFFF; sv[1] = 32'h800; sv[2] = 32'h7FF; sv[3] = 32'h123;
      send_frame(4, 1, 2, 1, 0, 0, -1);
      drained("R5 right justified drained");

      // R6 8 in 8, delay 1
      wr_fmt(fmw(0, 0, 3, 1, 0, 7));
      sv[0] = 32'h80; sv[1] = 32'h7F; sv[2] = 32'hA5;
      send_frame(3, 0, 0, 0, 1, 0, -1);
      // R6 20 in 24 right justified
      wr_fmt(fmw(3, 4, 2, 0, 1, 7));
      sv[0] = 32'h8_1234; sv[1] = 32'h5_4321;
      send_frame(2, 3, 4, 1, 0, 0, -1);
      drained("R6 size codes drained");

      // R8 polarity, 32 in 32
      wr_sp(spw(1, 0, 0, 0, 1, 0, 0));
      fs_in = 1'b1;
      wr_fmt(fmw(5, 5, 2, 0, 0, 7));
      sv[0] = 32'hDEAD_BEEF; sv[1] = 32'h0123_4567;
      send_frame(2, 5, 5, 0, 0, 1, -1);
      drained("R8 active-low frame sync");
      chk(fs_out == 1'b1, "R8 idle fs_out inverted", 32'(fs_out), 1);
      wr_sp(spw(1, 0, 0, 0, 0, 0, 0));
      fs_in = 1'b0;

      // R7 ticks after the last slot ignored
      for (int k = 0; k < 12; k++) tick(1'b0, k[0]);
      drained("R7 idle ticks after frame");

      // R10 threshold
      mon_on = 1'b0;
      wr_fmt(fmw(2, 2, 2, 0, 0, 2));
      sv[0] = 32'h1111; sv[1] = 32'h2222;
      send_frame(2, 2, 2, 0, 0, 0, -1);
      idle(5);
      chk(req == 1'b0, "R10 count 2 threshold 2", 32'(req), 0);
      wr_fmt(fmw(2, 2, 1, 0, 0, 2));
      sv[0] = 32'h3333;
      send_frame(1, 2, 2, 0, 0, 0, -1);
      idle(5);
      chk(req == 1'b1, "R10 count 3 threshold 2", 32'(req), 1);
      mon_on = 1'b1;
      drained("R10 drain");
      wr_fmt(fmw(2, 2, 1, 0, 0, 0));
      chk(req == 1'b0, "R10 empty threshold 0", 32'(req), 0);
      mon_on = 1'b0;
      sv[0] = 32'h4444;
      send_frame(1, 2, 2, 0, 0, 0, -1);
      idle(5);
      chk(req == 1'b1, "R10 one sample threshold 0", 32'(req), 1);
      mon_on = 1'b1;
      drained("R10 drain 2");

      // R11 overrun
      mon_on = 1'b0;
      wr_fmt(fmw(2, 2, 8, 0, 0, 7));
      for (int k = 0; k < 8; k++) sv[k] = 32'(k * 32'h1111 + 1);
      send_frame(8, 2, 2, 0, 0, 0, -1);
      idle(5);
      chk(!overrun && req, "R11 exactly full", {30'd0, overrun, req}, 1);
      for (int k = 0; k < 8; k++) sv[k] = 32'hAAAA;
      send_frame(8, 2, 2, 0, 0, 0, -1);
      idle(5);
      chk(overrun == 1'b1, "R11 overrun set", 32'(overrun), 1);
      mon_on = 1'b1;
      drained("R11 kept samples drained");
      chk(overrun == 1'b1, "R11 overrun sticky", 32'(overrun), 1);

      // R13 reset + flush
      mon_on = 1'b0;
      send_frame(8, 2, 2, 0, 0, 0, -1);
      idle(5);
      wr_sp(spw(1, 1, 1, 0, 0, 0, 0));
      exp_q.delete();
      idle(2);
      chk(!rd_valid && !overrun && !req, "R13 reset and flush", {29'd0, rd_valid, overrun, req}, 0);
      mon_on = 1'b1;

      // R12 resync
      wr_fmt(fmw(2, 2, 4, 0, 0, 7));
      sv[0] = 32'h0AAA; sv[1] = 32'h0BBB; sv[2] = 32'h0CCC; sv[3] = 32'h0DDD;
      send_frame(4, 2, 2, 0, 0, 0, -1);
      idle(3);
      chk(resync == 1'b0, "R12 no resync on clean frame", 32'(resync), 0);
      send_frame(4, 2, 2, 0, 0, 0, 24);
      sv[0] = 32'hF00F;
      send_frame(4, 2, 2, 0, 0, 0, -1);
      drained("R12 restarted frame drained");
      chk(resync == 1'b1, "R12 resync set", 32'(resync), 1);
      wr_sp(spw(1, 1, 0, 0, 0, 0, 0));
      idle(2);
      chk(resync == 1'b0, "R13 reset clears resync", 32'(resync), 0);

      // R9 master timing
      wr_fmt(fmw(0, 0, 2, 0, 0, 7));
      wr_sp(spw(1, 1, 1, 1, 0, 1, 19));
      begin
         int ft0;
         ft0 = ft_cnt; tk = 0;
         sv[0] = 32'h5A; sv[1] = 32'hC3;
         send_frame(2, 0, 0, 0, 0, 0, -1);
         for (int k = 0; k < 5; k++) tick(1'b0, 1'b0);
         idle(3);
         chk(ft_cnt - ft0 == 2, "R9 frame_tick per generated frame", 32'(ft_cnt - ft0), 2);
         chk(fs_hist[0] && fs_hist[1] && !fs_hist[2] && !fs_hist[19] && fs_hist[20],
             "R9 generated sync pattern",
             {27'd0, fs_hist[0], fs_hist[1], fs_hist[2], fs_hist[19], fs_hist[20]}, 5'b11001);
         chk(fs_oe == 1'b1, "R9 fs_oe in master", 32'(fs_oe), 1);
      end
      drained("R9 master frame drained");

      // R13 disabled port ignores ticks
      wr_sp(spw(0, 1, 1, 0, 0, 0, 0));
      begin
         int ft1;
         ft1 = ft_cnt;
         expect_on = 1'b0;
         send_frame(2, 0, 0, 0, 0, 0, -1);
         idle(5);
         chk(!rd_valid && ft_cnt == ft1, "R13 disabled ignores frame", 32'(ft_cnt - ft1), 0);
         expect_on = 1'b1;
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule